// File: doc/BRIEF.md
# Isolated Digital I/O Register Controller

This block gives a host a byte-wide register window onto sixteen output latches and sixteen input lines. The host drives a small synchronous bus: a 3-bit byte address, separate read and write strobes, an 8-bit write bus and a combinational 8-bit read bus. The device side drives a 16-bit output bus, samples a 16-bit raw input bus and raises one level interrupt request.

Each raw input is brought into the clock domain by two flops. It then passes an optional debounce stage that accepts a new level only once that level has held for a set number of cycles. The accepted input state feeds an edge detector. Any change, rising or falling, latches a pending flag for the byte in which it occurred. The interrupt line is the OR of the pending flags gated by an enable. The enable and the filter are not set through data bits. The type of access to their offset switches them: a read turns the function on and a write turns it off. Any write to the low input byte offset acknowledges pending events.

Top module: `isol_io_ctrl`

## Requirements
- R1: After reset, drive_out is 0, irq is 0, the status byte (offset 6) reads 0, the input bytes read 0 with inputs held low, and filtering and interrupts are off.
- R2: A write to offset 0 loads drive_out[7:0] and a write to offset 4 loads drive_out[15:8] on the next clock edge. A read of either offset returns the byte currently latched.
- R3: A read of offset 1 returns accepted inputs 0-7 and a read of offset 5 returns accepted inputs 8-15. A write to offset 5 changes no output, no latch and no pending state.
- R4: A read of offset 2 enables interrupts and a write of any value to offset 2 disables them. irq is high only while interrupts are enabled and an event is pending. Events latched while interrupts are disabled are kept and assert irq as soon as interrupts are enabled.
- R5: Status byte at offset 6: bit 0 = event pending on inputs 0-7, bit 1 = event pending on inputs 8-15, bit 2 = current irq level, bits 7:3 = 0. Both rising and falling changes set the pending bit.
- R6: A write of any value to offset 1 clears both pending bits, so irq falls and status bits 1:0 read 0.
- R7: A read of offset 3 turns filtering on and a write to offset 3 turns it off, for all 16 inputs. With filtering on, a change that holds for fewer than FILT_LEN cycles after synchronisation is ignored. It changes neither the input read nor the pending state. A change that holds longer is accepted.
- R8: With filtering off, a raw input change made before clock edge k is visible in the input read after edge k+2, and not after edge k+1.
- R9: When read and write strobes are both asserted, only the write takes effect. A combined access to offset 2 leaves interrupts disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Byte offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, 0 when no read) |
| drive_out | output | 16 | Output latch drive bus |
| raw_in | input | 16 | Unsynchronised input lines |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest states to reach are the ones that come from timing on the raw inputs against the filter window. One is a glitch just shorter than the debounce length, which must leave no trace. The other is a pulse that the unfiltered path accepts and then reverts, which leaves a pending event while the input reads back unchanged. The bench reaches both by driving raw_in on falling edges for exact cycle counts, with filtering first on and then off. It then reads the input and status bytes. A pending event held across a disable and re-enable is set up by changing inputs while interrupts are off, then enabling them by a read.

// File: rtl/dio_pkg.sv
package dio_pkg;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = 2;
    localparam int IO_W    = BYTE_W * N_BYTES;
    localparam int ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_OUT_LO  = 3'd0,
        OFS_IN_LO   = 3'd1,
        OFS_IRQ_CTL = 3'd2,
        OFS_FLT_CTL = 3'd3,
        OFS_OUT_HI  = 3'd4,
        OFS_IN_HI   = 3'd5,
        OFS_STATUS  = 3'd6,
        OFS_SPARE   = 3'd7
    } ofs_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        ofs_e             ofs;
        logic [BYTE_W-1:0] data;
    } bus_req_t;

    typedef struct packed {
        logic irq_en;
        logic flt_en;
    } ctl_t;

    function automatic logic [BYTE_W-1:0] status_byte(input logic irq_lvl,
                                                      input logic [N_BYTES-1:0] pnd);
        logic [BYTE_W-1:0] s;
        s = '0;
        s[N_BYTES-1:0] = pnd;
        s[N_BYTES]     = irq_lvl;
        return s;
    endfunction
endpackage

// File: rtl/dio_in_sync.sv
module dio_in_sync #(
    parameter int W        = 16,
    parameter int FILT_LEN = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flt_en,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] acc_q
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= raw_in;
            sync_q <= meta_q;
        end
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [CW-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q    <= '0;
                acc_q[b] <= 1'b0;
            end else if (!flt_en) begin
                cnt_q    <= '0;
                acc_q[b] <= sync_q[b];
            end else if (sync_q[b] == acc_q[b]) begin
                cnt_q    <= '0;
            end else if (cnt_q == CNT_LAST) begin
                cnt_q    <= '0;
                acc_q[b] <= sync_q[b];
            end else begin
                cnt_q    <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dio_cos.sv
module dio_cos #(
    parameter int GRP_W = 8,
    parameter int N_GRP = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [GRP_W*N_GRP-1:0] acc_in,
    input  logic                   clr,
    output logic [N_GRP-1:0]       cos_evt,
    output logic [N_GRP-1:0]       pend
);
    logic [GRP_W*N_GRP-1:0] prev_q;
    logic [GRP_W*N_GRP-1:0] diff;

    assign diff = acc_in ^ prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= acc_in;
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign cos_evt[g] = |diff[g*GRP_W +: GRP_W];
        always_ff @(posedge clk) begin
            if (rst)             pend[g] <= 1'b0;
            else if (cos_evt[g]) pend[g] <= 1'b1;
            else if (clr)        pend[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/dio_regs.sv
module dio_regs
    import dio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  bus_req_t             req,
    input  logic [IO_W-1:0]      acc_in,
    input  logic [N_BYTES-1:0]   pend,
    output logic [IO_W-1:0]      out_q,
    output ctl_t                 ctl_q,
    output logic                 clr_pend,
    output logic                 irq,
    output logic [BYTE_W-1:0]    rdata
);
    logic wr_hit;
    logic rd_hit;

    assign wr_hit   = req.wr;
    assign rd_hit   = req.rd && !req.wr;
    assign clr_pend = wr_hit && (req.ofs == OFS_IN_LO);
    assign irq      = ctl_q.irq_en && (|pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            ctl_q <= '0;
        end else begin
            if (wr_hit) begin
                unique case (req.ofs)
                    OFS_OUT_LO:  out_q[BYTE_W-1:0]      <= req.data;
                    OFS_OUT_HI:  out_q[IO_W-1:BYTE_W]   <= req.data;
                    OFS_IRQ_CTL: ctl_q.irq_en           <= 1'b0;
                    OFS_FLT_CTL: ctl_q.flt_en           <= 1'b0;
                    default: ;
                endcase
            end else if (rd_hit) begin
                unique case (req.ofs)
                    OFS_IRQ_CTL: ctl_q.irq_en <= 1'b1;
                    OFS_FLT_CTL: ctl_q.flt_en <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (req.rd) begin
            unique case (req.ofs)
                OFS_OUT_LO: rdata = out_q[BYTE_W-1:0];
                OFS_OUT_HI: rdata = out_q[IO_W-1:BYTE_W];
                OFS_IN_LO:  rdata = acc_in[BYTE_W-1:0];
                OFS_IN_HI:  rdata = acc_in[IO_W-1:BYTE_W];
                OFS_STATUS: rdata = status_byte(irq, pend);
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/isol_io_ctrl.sv
module isol_io_ctrl
    import dio_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [15:0]       drive_out,
    input  logic [15:0]       raw_in,
    output logic              irq
);
    bus_req_t             req;
    ctl_t                 ctl;
    logic                 irq_en;
    logic                 filt_en;
    logic [IO_W-1:0]      acc;
    logic [N_BYTES-1:0]   pend;
    logic [N_BYTES-1:0]   cos_evt;
    logic                 clr_pend;

    assign req.rd   = bus_rd;
    assign req.wr   = bus_wr;
    assign req.ofs  = ofs_e'(bus_addr);
    assign req.data = bus_wdata;
    assign irq_en   = ctl.irq_en;
    assign filt_en  = ctl.flt_en;

    dio_in_sync #(.W(IO_W), .FILT_LEN(FILT_LEN)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .flt_en (filt_en),
        .raw_in (raw_in),
        .acc_q  (acc)
    );

    dio_cos #(.GRP_W(BYTE_W), .N_GRP(N_BYTES)) u_cos (
        .clk     (clk),
        .rst     (rst),
        .acc_in  (acc),
        .clr     (clr_pend),
        .cos_evt (cos_evt),
        .pend    (pend)
    );

    dio_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .acc_in   (acc),
        .pend     (pend),
        .out_q    (drive_out),
        .ctl_q    (ctl),
        .clr_pend (clr_pend),
        .irq      (irq),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/isol_io_ctrl_chk.sv
module isol_io_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic [15:0] drive_out,
    input logic        irq,
    input logic        irq_en,
    input logic        filt_en,
    input logic [1:0]  pend,
    input logic [1:0]  cos_evt
);
    // R2
    out_lo_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd0) |=> drive_out[7:0] == $past(bus_wdata));
    // R2
    out_hi_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd4) |=> drive_out[15:8] == $past(bus_wdata));
    // R3
    in_hi_wr_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd5) |=> ($stable(drive_out) && $stable(irq_en) && $stable(filt_en)));
    // R4
    irq_off_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd2) |=> !irq);
    // R5
    status_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd6) |-> (bus_rdata[2] == irq && bus_rdata[7:3] == 5'd0 && bus_rdata[1:0] == pend));
    // R6
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd1 && cos_evt == 2'b00) |=> pend == 2'b00);
    // R7
    filt_on_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == 3'd3) |=> filt_en);
    // R9
    combo_wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_wr && bus_addr == 3'd2) |=> !irq_en);
endmodule

bind isol_io_ctrl isol_io_ctrl_chk u_chk (.*);

// File: tb/tb_isol_io_ctrl.sv
module tb_isol_io_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [15:0] drive_out;
    logic [15:0] raw_in;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    isol_io_ctrl #(.FILT_LEN(4)) dut (.*);

    // {output word, input word}
    localparam logic [31:0] VEC [6] = '{
        {16'hA5C3, 16'h0001},
        {16'h0000, 16'hFF00},
        {16'hFFFF, 16'h00FF},
        {16'h1234, 16'h8001},
        {16'h8001, 16'h5AA5},
        {16'h00FF, 16'h0000}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        rst = 1'b1; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0; raw_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        chk("R1 drive_out", drive_out, 16'h0);
        chk("R1 irq", {15'd0, irq}, 16'h0);
        brd(3'd6, r); chk("R1 status", {8'd0, r}, 16'h0);
        brd(3'd1, r); chk("R1 in_lo", {8'd0, r}, 16'h0);

        // R2 R3 table walk (interrupts off)
        foreach (VEC[i]) begin
            bwr(3'd0, VEC[i][23:16]);
            bwr(3'd4, VEC[i][31:24]);
            @(negedge clk); raw_in = VEC[i][15:0];
            idle(6);
            chk("R2 drive_out", drive_out, VEC[i][31:16]);
            brd(3'd0, r); chk("R2 rd out_lo", {8'd0, r}, {8'd0, VEC[i][23:16]});
            brd(3'd4, r); chk("R2 rd out_hi", {8'd0, r}, {8'd0, VEC[i][31:24]});
            brd(3'd1, r); chk("R3 rd in_lo", {8'd0, r}, {8'd0, VEC[i][7:0]});
            brd(3'd5, r); chk("R3 rd in_hi", {8'd0, r}, {8'd0, VEC[i][15:8]});
            chk("R4 irq held low while disabled", {15'd0, irq}, 16'h0);
        end
        bwr(3'd1, 8'h00);
        brd(3'd6, r); chk("R6 cleared", {8'd0, r}, 16'h0);

        // R4 R5 pending kept while disabled, rising edge low byte
        @(negedge clk); raw_in = 16'h0004;
        idle(6);
        brd(3'd6, r); chk("R5 status lo pend, irq off", {8'd0, r}, 16'h0001);
        chk("R4 irq off", {15'd0, irq}, 16'h0);
        brd(3'd2, r);
        chk("R4 irq after enable", {15'd0, irq}, 16'h1);
        brd(3'd6, r); chk("R5 status with irq", {8'd0, r}, 16'h0005);

        // R3 write to in_hi inert
        bwr(3'd5, 8'hFF);
        brd(3'd6, r); chk("R3 in_hi write keeps status", {8'd0, r}, 16'h0005);
        chk("R3 in_hi write keeps drive_out", drive_out, 16'h00FF);

        // R6 clear
        bwr(3'd1, 8'h5A);
        chk("R6 irq low after clear", {15'd0, irq}, 16'h0);
        brd(3'd6, r); chk("R6 status after clear", {8'd0, r}, 16'h0);

        // R5 falling edge high byte
        @(negedge clk); raw_in = 16'h8004;
        idle(6); bwr(3'd1, 8'h00);
        @(negedge clk); raw_in = 16'h0004;
        idle(6);
        brd(3'd6, r); chk("R5 falling edge hi", {8'd0, r}, 16'h0006);

        // R4 disable keeps pending, re-enable restores irq
        bwr(3'd2, 8'h00);
        chk("R4 irq off after disable", {15'd0, irq}, 16'h0);
        brd(3'd6, r); chk("R4 pending kept", {8'd0, r}, 16'h0002);
        brd(3'd2, r);
        chk("R4 irq back on", {15'd0, irq}, 16'h1);
        bwr(3'd1, 8'h00);

        // R7 filter on: 3-cycle glitch rejected
        brd(3'd3, r);
        @(negedge clk); raw_in = 16'h0005;
        idle(3);
        raw_in = 16'h0004;
        idle(10);
        brd(3'd1, r); chk("R7 glitch not seen", {8'd0, r}, 16'h0004);
        brd(3'd6, r); chk("R7 glitch no pend", {8'd0, r}, 16'h0);
        // long change accepted
        @(negedge clk); raw_in = 16'h0005;
        idle(10);
        brd(3'd1, r); chk("R7 long change seen", {8'd0, r}, 16'h0005);
        brd(3'd6, r); chk("R7 long change pend", {8'd0, r}, 16'h0005);
        bwr(3'd1, 8'h00);
        // filter off: same glitch accepted and leaves pending
        bwr(3'd3, 8'h00);
        @(negedge clk); raw_in = 16'h0004;
        idle(3);
        raw_in = 16'h0005;
        idle(8);
        brd(3'd1, r); chk("R7 off: level restored", {8'd0, r}, 16'h0005);
        brd(3'd6, r); chk("R7 off: glitch pend", {8'd0, r}, 16'h0005);
        bwr(3'd1, 8'h00);

        // R8 latency with filter off
        @(negedge clk); bus_addr = 3'd1; bus_rd = 1'b1;
        raw_in = 16'h0007;
        @(posedge clk); @(posedge clk); @(negedge clk); #1;
        chk("R8 not yet after 2 edges", {8'd0, bus_rdata}, 16'h0005);
        @(negedge clk); #1;
        chk("R8 visible after 3 edges", {8'd0, bus_rdata}, 16'h0007);
        bus_rd = 1'b0;
        idle(4);

        // R9 combined read/write to offset 2 disables
        @(negedge clk); bus_addr = 3'd2; bus_rd = 1'b1; bus_wr = 1'b1;
        @(negedge clk); bus_rd = 1'b0; bus_wr = 1'b0;
        chk("R9 irq stays off", {15'd0, irq}, 16'h0);
        brd(3'd6, r); chk("R9 pend kept, irq off", {8'd0, r}, 16'h0001);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule